// File: doc/BRIEF.md
# Decimal Field and Record Mover

This block copies variable-length decimal data from one place in a digit-addressed memory to another. Each memory location holds a single 6-bit digit. Bit 5 is the check bit, bit 4 is the flag bit, and bits 3..0 hold the BCD value. Addresses are five BCD digits, packed four bits per digit with the units digit in bits 3..0.

The length of a transfer is not given as a count. It is marked inside the data itself.

- **Field mode** (`rec_mode` = 0): the mover starts at the units end of a field and walks toward lower addresses. It stops after copying the first flagged digit that is not the units digit. The flag on the units digit is a sign, not a terminator.
- **Record mode** (`rec_mode` = 1): the mover starts at the leftmost digit and walks toward higher addresses. It stops after copying the record mark.

The controller is a small state machine:

- `S_IDLE` waits for `start`. On `start` it latches the addresses and mode and goes to `S_FETCH`.
- `S_FETCH` issues a read of the source address and always goes to `S_STORE`.
- `S_STORE` examines the returned digit and does one of four things:
  - goes to `S_PERR` on a parity fault;
  - writes the digit and goes to `S_FINISH` on a terminator;
  - writes the digit and goes to `S_AERR` when the next address step would leave the range;
  - otherwise writes the digit, steps both addresses and returns to `S_FETCH`.
- `S_FINISH`, `S_PERR` and `S_AERR` each last one cycle, raise their own pulse, and return to `S_IDLE`.

Each digit therefore costs two cycles: one to read and one to write.

Top module: `dfm_mover`

## Requirements
- R1: After reset, `busy`, `done`, `par_err`, `addr_err`, `mem_re` and `mem_we` are all low.
- R2: In the cycle after `start` is sampled in `S_IDLE`, `mem_re` is high and `mem_addr` equals `src_addr`. Each digit is read in one cycle and written unchanged (all 6 bits) to the destination address in the next cycle.
- R3: In field mode, both addresses step down by one (BCD) after each digit. A flag on the first (units) digit does not end the transfer.
- R4: In field mode, the transfer ends after writing the first flagged digit beyond the units digit. `done` pulses in the following cycle, 2N+1 cycles after the start edge for an N-digit field. The shortest field is two digits.
- R5: In record mode, both addresses step up by one (BCD). Flag bits do not end the transfer. It ends after writing the record mark, which is exactly 6'b101010 (check, 8 and 2 set). `done` pulses in the following cycle.
- R6: A read digit whose six bits hold an even number of ones is not written. `par_err` pulses in the next cycle and the transfer stops.
- R7: If, after a non-terminating digit is written, either address would step below 00000 or above 19999, `addr_err` pulses in the next cycle and the transfer stops.
- R8: A `start` raised while a transfer is running, or during an outcome cycle, is ignored.
- R9: `done`, `par_err` and `addr_err` are one-cycle pulses. At most one of them is high at a time, and `busy` is low while any of them is high.
- R10: Address stepping carries and borrows across decimal digits, for example 00100 to 00099 and 09999 to 10000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer; sampled only when idle |
| rec_mode | input | 1 | 0 = field mode (downward), 1 = record mode (upward) |
| src_addr | input | 20 | BCD source start address |
| dst_addr | input | 20 | BCD destination start address |
| mem_addr | output | 20 | BCD memory address for the current read or write |
| mem_re | output | 1 | Read strobe; data is returned on `mem_rdata` in the next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 6 | Digit to write |
| mem_rdata | input | 6 | Digit read from memory |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Pulse: transfer ended on its terminator |
| par_err | output | 1 | Pulse: parity fault, transfer stopped |
| addr_err | output | 1 | Pulse: address left the legal range, transfer stopped |

## Verification
The bench builds the mover with its default parameters: five address digits and a top digit limited to 1. With these values the 00000 floor and the 19999 ceiling can both be reached in a few cycles, whether the range is left by the source or by the destination. The same settings let short transfers cross the decimal carry and borrow points 00099/00100 and 09999/10000. Fields as short as two digits, a bad digit in mid-field, and a stray `start` during a running transfer are each driven in their own task.

// File: rtl/dfm_pkg.sv
package dfm_pkg;
    typedef logic [5:0] digit_t;

    localparam int     CHK_BIT  = 5;
    localparam int     FLAG_BIT = 4;
    localparam digit_t REC_MARK = 6'b101010;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_STORE,
        S_FINISH,
        S_PERR,
        S_AERR
    } state_t;
endpackage

// File: rtl/dfm_step.sv
module dfm_step #(
    parameter int NDIG    = 5,
    parameter int TOP_MAX = 1
) (
    input  logic [4*NDIG-1:0] addr_i,
    input  logic              down_i,
    output logic [4*NDIG-1:0] next_o,
    output logic              oob_o
);
    localparam int AW = 4 * NDIG;

    always_comb begin
        logic       cy;
        logic [3:0] d;
        cy     = 1'b1;
        next_o = addr_i;
        for (int i = 0; i < NDIG; i++) begin
            d = addr_i[4*i +: 4];
            if (cy) begin
                if (down_i) begin
                    if (d == 4'd0) begin
                        d  = 4'd9;
                        cy = 1'b1;
                    end else begin
                        d  = d - 4'd1;
                        cy = 1'b0;
                    end
                end else begin
                    if (d == 4'd9) begin
                        d  = 4'd0;
                        cy = 1'b1;
                    end else begin
                        d  = d + 4'd1;
                        cy = 1'b0;
                    end
                end
            end
            next_o[4*i +: 4] = d;
        end
        oob_o = cy || (next_o[AW-1 -: 4] > 4'(TOP_MAX));
    end
endmodule

// File: rtl/dfm_digit_chk.sv
module dfm_digit_chk
    import dfm_pkg::*;
(
    input  digit_t dig_i,
    output logic   par_ok_o,
    output logic   flag_o,
    output logic   recmark_o
);
    always_comb begin
        par_ok_o  = ^dig_i;
        flag_o    = dig_i[FLAG_BIT];
        recmark_o = (dig_i == REC_MARK);
    end
endmodule

// File: rtl/dfm_mover.sv
module dfm_mover
    import dfm_pkg::*;
#(
    parameter int NDIG    = 5,
    parameter int TOP_MAX = 1,
    localparam int AW     = 4 * NDIG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rec_mode,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    output logic [AW-1:0] mem_addr,
    output logic          mem_re,
    output logic          mem_we,
    output logic [5:0]    mem_wdata,
    input  logic [5:0]    mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          par_err,
    output logic          addr_err
);
    state_t        state_q, state_d;
    logic [AW-1:0] src_q, dst_q, src_nxt, dst_nxt;
    logic          rec_q, first_q;
    logic          src_oob, dst_oob;
    logic          par_ok, flag_seen, recmark_seen, end_hit;

    dfm_step #(.NDIG(NDIG), .TOP_MAX(TOP_MAX)) i_src_step (
        .addr_i(src_q), .down_i(!rec_q), .next_o(src_nxt), .oob_o(src_oob));

    dfm_step #(.NDIG(NDIG), .TOP_MAX(TOP_MAX)) i_dst_step (
        .addr_i(dst_q), .down_i(!rec_q), .next_o(dst_nxt), .oob_o(dst_oob));

    dfm_digit_chk i_chk (
        .dig_i(mem_rdata), .par_ok_o(par_ok),
        .flag_o(flag_seen), .recmark_o(recmark_seen));

    assign end_hit = rec_q ? recmark_seen : (flag_seen && !first_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_FETCH;
            S_FETCH:  state_d = S_STORE;
            S_STORE: begin
                if (!par_ok)                state_d = S_PERR;
                else if (end_hit)           state_d = S_FINISH;
                else if (src_oob || dst_oob) state_d = S_AERR;
                else                        state_d = S_FETCH;
            end
            S_FINISH, S_PERR, S_AERR: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            src_q   <= '0;
            dst_q   <= '0;
            rec_q   <= 1'b0;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start) begin
                src_q   <= src_addr;
                dst_q   <= dst_addr;
                rec_q   <= rec_mode;
                first_q <= 1'b1;
            end else if (state_q == S_STORE && state_d == S_FETCH) begin
                src_q   <= src_nxt;
                dst_q   <= dst_nxt;
                first_q <= 1'b0;
            end
        end
    end

    always_comb begin
        mem_addr  = '0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = mem_rdata;
        busy      = 1'b0;
        done      = 1'b0;
        par_err   = 1'b0;
        addr_err  = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_FETCH: begin
                busy     = 1'b1;
                mem_re   = 1'b1;
                mem_addr = src_q;
            end
            S_STORE: begin
                busy     = 1'b1;
                mem_addr = dst_q;
                mem_we   = par_ok;
            end
            S_FINISH: done     = 1'b1;
            S_PERR:   par_err  = 1'b1;
            S_AERR:   addr_err = 1'b1;
            default: ;
        endcase
    end

    a_r6_write_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ^mem_wdata);
    a_r2_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(mem_re));
    a_r2_no_read_write_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));
    a_r9_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, par_err, addr_err}));
    a_r9_outcome_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (done || par_err || addr_err) |-> !busy);
    a_r9_outcome_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done || par_err || addr_err) |=> !(done || par_err || addr_err));
    a_r4_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_we));
    a_r6_perr_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> ($past(busy) && !$past(mem_we)));
    a_r7_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re || mem_we) |-> (mem_addr[AW-1 -: 4] <= 4'(TOP_MAX)));
endmodule

// File: tb/test_dfm_mover.sv
`timescale 1ns/1ps
module test_dfm_mover;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rec_mode = 1'b0;
    logic [19:0] src_addr = '0, dst_addr = '0;
    logic [19:0] mem_addr;
    logic        mem_re, mem_we;
    logic [5:0]  mem_wdata;
    logic [5:0]  mem_rdata = '0;
    logic        busy, done, par_err, addr_err;

    int checks = 0;
    int fails  = 0;
    int wcount = 0;
    logic [5:0] mem [int];

    always #2.5 clk = ~clk;

    dfm_mover i_dfm_mover (
        .clk(clk), .rst_n(rst_n), .start(start), .rec_mode(rec_mode),
        .src_addr(src_addr), .dst_addr(dst_addr), .mem_addr(mem_addr),
        .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .par_err(par_err), .addr_err(addr_err));

    function automatic int b2i(input logic [19:0] a);
        int v = 0;
        for (int i = 4; i >= 0; i--) v = v * 10 + int'(a[4*i +: 4]);
        return v;
    endfunction

    function automatic logic [19:0] i2b(input int v);
        logic [19:0] a = '0;
        int t = v;
        for (int i = 0; i < 5; i++) begin
            a[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return a;
    endfunction

    function automatic logic [5:0] enc(input int val, input bit f);
        logic [3:0] v = 4'(val);
        logic c = ~(^{f, v});
        return {c, f, v};
    endfunction

    function automatic logic [5:0] rd(input int a);
        if (mem.exists(a)) return mem[a];
        return 6'h3f;
    endfunction

    always @(posedge clk) if (mem_re) mem_rdata <= rd(b2i(mem_addr));
    always @(posedge clk) if (mem_we) begin
        mem[b2i(mem_addr)] = mem_wdata;
        wcount++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic clear_mem;
        mem.delete();
        wcount = 0;
    endtask

    // outc: 0 done, 1 parity, 2 address, 3 none
    task automatic run(input logic rec, input int s, input int d, input bit poke,
                       output int cyc, output int outc);
        @(negedge clk);
        rec_mode = rec; src_addr = i2b(s); dst_addr = i2b(d); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        chk(mem_re && b2i(mem_addr) == s, "R2", "first read at source",
            b2i(mem_addr), s);
        while (!(done || par_err || addr_err) && cyc < 500) begin
            if (poke && cyc == 3) begin
                start = 1'b1; rec_mode = ~rec; src_addr = i2b(0); dst_addr = i2b(10);
            end
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        outc = done ? 0 : par_err ? 1 : addr_err ? 2 : 3;
        chk(!busy && (int'(done) + int'(par_err) + int'(addr_err)) == 1, "R9",
            "single outcome, not busy", int'(done) + int'(par_err) + int'(addr_err), 1);
        @(negedge clk);
        chk(!(done || par_err || addr_err || busy), "R9", "outcome is a one-cycle pulse",
            int'(done || par_err || addr_err || busy), 0);
    endtask

    task automatic t_reset;
        chk(!busy && !done && !par_err && !addr_err && !mem_re && !mem_we, "R1",
            "outputs low after reset",
            int'({busy, done, par_err, addr_err, mem_re, mem_we}), 0);
    endtask

    task automatic t_field_basic;
        int cyc, outc;
        clear_mem();
        mem[500] = enc(3, 1); mem[501] = enc(4, 0); mem[502] = enc(5, 0);
        mem[503] = enc(6, 0); mem[504] = enc(7, 1);
        run(1'b0, 504, 804, 1'b0, cyc, outc);
        chk(outc == 0, "R4", "field ends with done", outc, 0);
        chk(cyc == 11, "R4", "done cycle for 5 digits", cyc, 11);
        chk(wcount == 5, "R3", "digits written", wcount, 5);
        for (int i = 0; i < 5; i++)
            chk(rd(800 + i) == rd(500 + i), "R3", "field digit copied with flag",
                int'(rd(800 + i)), int'(rd(500 + i)));
        chk(rd(799) == 6'h3f, "R4", "no write past flag", int'(rd(799)), 63);
        // shortest field: flagged units digit then flagged neighbour
        clear_mem();
        mem[49] = enc(2, 1); mem[50] = enc(1, 1);
        run(1'b0, 50, 60, 1'b0, cyc, outc);
        chk(outc == 0 && cyc == 5, "R4", "two-digit field done cycle", cyc, 5);
        chk(wcount == 2 && rd(59) == enc(2, 1) && rd(60) == enc(1, 1), "R3",
            "sign flag did not stop, two digits copied", wcount, 2);
    endtask

    task automatic t_field_borrow;
        int cyc, outc;
        clear_mem();
        mem[101] = enc(9, 0); mem[100] = enc(1, 0); mem[99] = enc(8, 1);
        run(1'b0, 101, 201, 1'b0, cyc, outc);
        chk(outc == 0 && cyc == 7, "R10", "borrow field done cycle", cyc, 7);
        chk(rd(199) == enc(8, 1) && rd(200) == enc(1, 0) && rd(201) == enc(9, 0),
            "R10", "digits across 00100/00099", int'(rd(199)), int'(enc(8, 1)));
    endtask

    task automatic t_record;
        int cyc, outc;
        clear_mem();
        mem[9998] = enc(4, 1); mem[9999] = enc(0, 0); mem[10000] = 6'b101010;
        mem[10001] = enc(5, 0);
        run(1'b1, 9998, 700, 1'b0, cyc, outc);
        chk(outc == 0 && cyc == 7, "R5", "record done cycle", cyc, 7);
        chk(wcount == 3, "R5", "record digits written", wcount, 3);
        chk(rd(700) == enc(4, 1) && rd(701) == enc(0, 0), "R5",
            "flag does not end record", int'(rd(700)), int'(enc(4, 1)));
        chk(rd(702) == 6'b101010, "R10", "record mark read from 10000 copied",
            int'(rd(702)), 42);
    endtask

    task automatic t_parity;
        int cyc, outc;
        clear_mem();
        mem[304] = enc(7, 1); mem[303] = enc(5, 0) ^ 6'b100000; mem[302] = enc(2, 1);
        run(1'b0, 304, 404, 1'b0, cyc, outc);
        chk(outc == 1, "R6", "parity outcome", outc, 1);
        chk(cyc == 5, "R6", "par_err cycle", cyc, 5);
        chk(wcount == 1 && rd(403) == 6'h3f, "R6", "bad digit not written", wcount, 1);
    endtask

    task automatic t_addr;
        int cyc, outc;
        clear_mem();
        mem[1] = enc(2, 1); mem[0] = enc(3, 0);
        run(1'b0, 1, 901, 1'b0, cyc, outc);
        chk(outc == 2 && cyc == 5, "R7", "source below 00000", cyc, 5);
        chk(wcount == 2 && rd(900) == enc(3, 0), "R7", "digits before fault written",
            wcount, 2);
        clear_mem();
        mem[500] = enc(1, 0); mem[501] = enc(2, 0); mem[502] = enc(3, 0);
        run(1'b1, 500, 19998, 1'b0, cyc, outc);
        chk(outc == 2 && cyc == 5, "R7", "destination above 19999", cyc, 5);
        chk(wcount == 2 && rd(19999) == enc(2, 0), "R7", "last legal write", wcount, 2);
    endtask

    task automatic t_busy_start;
        int cyc, outc;
        clear_mem();
        mem[500] = enc(3, 1); mem[501] = enc(4, 0); mem[502] = enc(5, 1);
        run(1'b0, 502, 802, 1'b1, cyc, outc);
        chk(outc == 0 && cyc == 7, "R8", "transfer unaffected by stray start", cyc, 7);
        chk(wcount == 3 && rd(10) == 6'h3f, "R8", "no write from stray start",
            wcount, 3);
        @(negedge clk);
        chk(!busy, "R8", "idle after run", int'(busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1-R10 actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_field_basic();
        t_field_borrow();
        t_record();
        t_parity();
        t_addr();
        t_busy_start();
        summary();
        $finish;
    end
endmodule